// File: doc/BRIEF.md
# Masked-Write GPIO Bank with Shared Interrupt

This block is a bank of sixteen general-purpose pins controlled through a word-wide register bus. Software sets the direction of every pin, drives output levels through a write that carries its own per-bit mask, reads synchronised pin levels back, and picks which of the upper eight pins may contribute to one shared, active-high, level-sensitive interrupt request. Each of the lower eight pins has its own request line, which follows the synchronised pin level.

A two-bit control register holds the bank in reset and gates its clock. Coming out of system reset, the bank is held in reset with its clock gated. Software brings it up by writing 3 and then 1 to that register. Writing 2 puts it back into reset and gates the clock.

The bus is a single-cycle write port. Read data is combinational from the address. Offsets are byte addresses: direction 0x00, output 0x08, pin state 0x0C, interrupt enable 0x10, control 0x14.

Top module: `mgpio_bank`

## Requirements
- R1: After system reset the control register reads 2 (bank held in reset, clock gated). Every other register, padOe, padOut, pinIrq and sharedIrq are 0.
- R2: The direction register (offset 0x00) is replaced by bits 15:0 of a write. A 1 in bit n drives padOe[n] high (output) and a 0 leaves the pin as an input. The register reads back its stored value.
- R3: A write to the output register (offset 0x08) changes output bit n to write bit n only when write bit n+16 is 1. All other output bits keep their value. padOut shows the register, and reads return it in bits 15:0.
- R4: The pin-state register (offset 0x0C) returns padIn passed through two clock stages. A pin change that is present before edge k is visible after edge k+1.
- R5: The interrupt-enable register (offset 0x10) is replaced by bits 15:0 of a write and reads back its stored value.
- R6: sharedIrq is high exactly when the bank runs and, for some pin n in 8..15, pin-state bit n and enable bit n are both 1.
- R7: pinIrq[n] for n in 0..7 equals pin-state bit n, with no enable gating.
- R8: The control register (offset 0x14) takes bits 1:0 of every write, in any state. Bit 1 holds the bank in reset and bit 0 enables its clock. While bit 1 is set, the direction, output, enable and pin-state registers are 0 and writes to them are ignored.
- R9: While bit 0 of the control register is 0 and bit 1 is 0, the pin state holds its last value, sharedIrq is low, and writes to the direction, output and enable registers are ignored.
- R10: Reads of any offset not listed above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and bank clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| busWe | input | 1 | Write strobe, one write per cycle |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| padIn | input | 16 | Pin levels from the pads |
| padOut | output | 16 | Output levels to the pads |
| padOe | output | 16 | Output enables to the pads (1 = drive) |
| pinIrq | output | 8 | Individual requests of pins 0..7 |
| sharedIrq | output | 1 | Combined request of pins 8..15 |

## Verification
Four behaviours are checked by the assertions on every cycle:
- a control write lands in the control register;
- reset clears the storage;
- a gated clock freezes the pin state;
- a masked output write leaves unmasked bits alone.

The assertions also require that sharedIrq is never raised without an enabled upper pin.

Only the bench's scenarios can show the rest. These cover the two-stage latency of pin sampling, the exact combination of levels and enables that raises the shared request, and writes being ignored before bring-up and while gated. They also cover the read-back of every offset, including unmapped ones, all compared against a behavioural model on every clock.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;
  localparam int ADDR_W   = 5;
  localparam logic [ADDR_W-1:0] OFS_DIR = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_OUT = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_PIN = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_IEN = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CTL = 5'h14;

  typedef enum logic [2:0] {
    RD_NONE, RD_DIR, RD_OUT, RD_PIN, RD_IEN, RD_CTL
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   dirWr;
    logic   outWr;
    logic   ienWr;
    logic   bankRst;
    logic   clkOn;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/mgpio_ctrl.sv
module mgpio_ctrl
  import mgpio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        ctlIn,
  output strobe_t           stb
);
  logic [1:0] ctlReg;
  logic       ctlWr;
  logic       running;

  assign ctlWr   = busWe && (busAddr == OFS_CTL);
  assign running = ctlReg[0] && !ctlReg[1];

  // bit 1 = hold in reset, bit 0 = clock on; comes up held and gated
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ctlReg <= 2'b10;
    else if (ctlWr) ctlReg <= ctlIn;
  end

  always_comb begin
    stb.bankRst = ctlReg[1];
    stb.clkOn   = ctlReg[0];
    stb.dirWr   = busWe && running && (busAddr == OFS_DIR);
    stb.outWr   = busWe && running && (busAddr == OFS_OUT);
    stb.ienWr   = busWe && running && (busAddr == OFS_IEN);
    case (busAddr)
      OFS_DIR: stb.rdSel = RD_DIR;
      OFS_OUT: stb.rdSel = RD_OUT;
      OFS_PIN: stb.rdSel = RD_PIN;
      OFS_IEN: stb.rdSel = RD_IEN;
      OFS_CTL: stb.rdSel = RD_CTL;
      default: stb.rdSel = RD_NONE;
    endcase
  end

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> ctlReg == $past(ctlIn)); // R8
endmodule

// File: rtl/mgpio_dpath.sv
module mgpio_dpath
  import mgpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int SHARE_LO = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [2*NUM_PINS-1:0] wdata,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [2*NUM_PINS-1:0] rdata,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [SHARE_LO-1:0]   pinIrq,
  output logic                  sharedIrq
);
  localparam int DATA_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] dirReg, outReg, ienReg, syncA, pinState;
  logic [NUM_PINS-1:0] wMask, wBits;

  assign wBits = wdata[NUM_PINS-1:0];
  assign wMask = wdata[DATA_W-1:NUM_PINS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0; outReg <= '0; ienReg <= '0;
    end else if (stb.bankRst) begin
      dirReg <= '0; outReg <= '0; ienReg <= '0;
    end else begin
      if (stb.dirWr) dirReg <= wBits;
      if (stb.ienWr) ienReg <= wBits;
      if (stb.outWr) outReg <= (outReg & ~wMask) | (wBits & wMask);
    end
  end

  // two-stage pin sampler, frozen while the clock is gated
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0; pinState <= '0;
    end else if (stb.bankRst) begin
      syncA <= '0; pinState <= '0;
    end else if (stb.clkOn) begin
      syncA    <= padIn;
      pinState <= syncA;
    end
  end

  assign padOut = outReg;
  assign padOe  = dirReg;

  for (genvar i = 0; i < SHARE_LO; i++) begin : g_pinIrq
    assign pinIrq[i] = pinState[i];
  end

  assign sharedIrq = stb.clkOn && !stb.bankRst &&
                     |(pinState[NUM_PINS-1:SHARE_LO] & ienReg[NUM_PINS-1:SHARE_LO]);

  always_comb begin
    rdata = '0;
    case (stb.rdSel)
      RD_DIR:  rdata[NUM_PINS-1:0] = dirReg;
      RD_OUT:  rdata[NUM_PINS-1:0] = outReg;
      RD_PIN:  rdata[NUM_PINS-1:0] = pinState;
      RD_IEN:  rdata[NUM_PINS-1:0] = ienReg;
      RD_CTL:  rdata[1:0] = {stb.bankRst, stb.clkOn};
      default: rdata = '0;
    endcase
  end

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.bankRst |=> (dirReg == '0 && outReg == '0 && ienReg == '0 && pinState == '0)); // R8
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clkOn && !stb.bankRst) |=> $stable(pinState)); // R9
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.outWr && !stb.bankRst) |=> ((outReg ^ $past(outReg)) & ~$past(wMask)) == '0); // R3
  AST_SHARED_SRC: assert property (@(posedge clk) disable iff (!rstN)
    sharedIrq |-> (ienReg[NUM_PINS-1:SHARE_LO] != '0)); // R6
endmodule

// File: rtl/mgpio_bank.sv
module mgpio_bank
  import mgpio_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int SHARE_LO = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [2*NUM_PINS-1:0] busWdata,
  output logic [2*NUM_PINS-1:0] busRdata,
  input  logic [NUM_PINS-1:0]   padIn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [SHARE_LO-1:0]   pinIrq,
  output logic                  sharedIrq
);
  strobe_t stb;

  mgpio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .ctlIn(busWdata[1:0]), .stb(stb)
  );

  mgpio_dpath #(.NUM_PINS(NUM_PINS), .SHARE_LO(SHARE_LO)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .padIn(padIn),
    .rdata(busRdata), .padOut(padOut), .padOe(padOe),
    .pinIrq(pinIrq), .sharedIrq(sharedIrq)
  );
endmodule

// File: tb/sim_mgpio_bank.sv
module sim_mgpio_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] padIn = '0;
  logic [15:0] padOut, padOe;
  logic [7:0]  pinIrq;
  logic        sharedIrq;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // behavioural reference state
  logic [15:0] mDir = '0, mOut = '0, mIen = '0, mS1 = '0, mSt = '0;
  logic [1:0]  mCtl = 2'b10;

  mgpio_bank u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .pinIrq(pinIrq), .sharedIrq(sharedIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [15:0] nS1, nSt, msk;
    if (!rstN) begin
      mDir = '0; mOut = '0; mIen = '0; mS1 = '0; mSt = '0; mCtl = 2'b10;
    end else begin
      nS1 = mS1; nSt = mSt;
      if (mCtl[1]) begin
        mDir = '0; mOut = '0; mIen = '0; nS1 = '0; nSt = '0;
      end else begin
        if (mCtl[0]) begin nSt = mS1; nS1 = padIn; end
        if (mCtl[0] && busWe) begin
          msk = busWdata[31:16];
          if (busAddr == 5'h00) mDir = busWdata[15:0];
          if (busAddr == 5'h10) mIen = busWdata[15:0];
          if (busAddr == 5'h08)
            for (int i = 0; i < 16; i++) if (msk[i]) mOut[i] = busWdata[i];
        end
      end
      mS1 = nS1; mSt = nSt;
      if (busWe && busAddr == 5'h14) mCtl = busWdata[1:0];
    end
  end

  always @(negedge clk) begin
    logic [31:0] expRd;
    logic        expSh;
    cycles++;
    if (rstN) begin
      expSh = 1'b0;
      if (mCtl == 2'b01)
        for (int i = 8; i < 16; i++) if (mSt[i] && mIen[i]) expSh = 1'b1;
      chk("R2 padOe", {16'h0, padOe}, {16'h0, mDir});
      chk("R3 padOut", {16'h0, padOut}, {16'h0, mOut});
      chk("R7 pinIrq", {24'h0, pinIrq}, {24'h0, mSt[7:0]});
      chk("R6 sharedIrq", {31'h0, sharedIrq}, {31'h0, expSh});
      case (busAddr)
        5'h00: begin expRd = {16'h0, mDir}; chk("R2 read", busRdata, expRd); end
        5'h08: begin expRd = {16'h0, mOut}; chk("R3 read", busRdata, expRd); end
        5'h0C: begin expRd = {16'h0, mSt};  chk("R4 read", busRdata, expRd); end
        5'h10: begin expRd = {16'h0, mIen}; chk("R5 read", busRdata, expRd); end
        5'h14: begin expRd = {30'h0, mCtl}; chk("R8 read", busRdata, expRd); end
        default: chk("R10 read", busRdata, 32'h0);
      endcase
    end
    if (cycles > 20000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk); #1;
    busAddr = a;
    @(negedge clk);
    chk(tag, busRdata, exp);
  endtask

  task automatic pins(input logic [15:0] v);
    @(negedge clk); #1;
    padIn = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    rdChk("R1 ctl after reset", 5'h14, 32'h2);
    rdChk("R1 dir after reset", 5'h00, 32'h0);
    chk("R1 sharedIrq", {31'h0, sharedIrq}, 32'h0);
    // writes before bring-up are dropped
    wr(5'h00, 32'h0000_FFFF);
    rdChk("R8 dir write ignored in reset", 5'h00, 32'h0);
    wr(5'h14, 32'h3);
    wr(5'h14, 32'h1);
    rdChk("R8 ctl running", 5'h14, 32'h1);
    wr(5'h00, 32'h0000_00FF);
    rdChk("R2 dir", 5'h00, 32'h0000_00FF);
    wr(5'h08, 32'h00FF_A5A5);
    rdChk("R3 masked low byte", 5'h08, 32'h0000_00A5);
    wr(5'h08, 32'hFF00_FFFF);
    rdChk("R3 masked high byte", 5'h08, 32'h0000_FFA5);
    wr(5'h08, 32'h0000_0000);
    rdChk("R3 empty mask", 5'h08, 32'h0000_FFA5);
    wr(5'h08, 32'h0081_0000);
    rdChk("R3 clear two bits", 5'h08, 32'h0000_FF24);
    pins(16'h005A);
    chk("R7 lower pins", {24'h0, pinIrq}, 32'h5A);
    rdChk("R4 pin state", 5'h0C, 32'h0000_005A);
    wr(5'h10, 32'h0000_0400);
    rdChk("R5 ien", 5'h10, 32'h0000_0400);
    pins(16'h0200);
    chk("R6 unenabled pin", {31'h0, sharedIrq}, 32'h0);
    pins(16'h0600);
    chk("R6 enabled pin", {31'h0, sharedIrq}, 32'h1);
    // gate the clock: state frozen, request low, writes dropped
    wr(5'h14, 32'h0);
    pins(16'h0000);
    chk("R9 shared low when gated", {31'h0, sharedIrq}, 32'h0);
    rdChk("R9 pin state held", 5'h0C, 32'h0000_0600);
    wr(5'h00, 32'h0000_0F0F);
    rdChk("R9 dir write ignored", 5'h00, 32'h0000_00FF);
    wr(5'h14, 32'h2);
    rdChk("R8 out cleared", 5'h08, 32'h0);
    rdChk("R8 ien cleared", 5'h10, 32'h0);
    rdChk("R8 pin state cleared", 5'h0C, 32'h0);
    wr(5'h14, 32'h3);
    wr(5'h14, 32'h1);
    pins(16'hFFFF);
    rdChk("R4 all high", 5'h0C, 32'h0000_FFFF);
    rdChk("R10 offset 0x04", 5'h04, 32'h0);
    rdChk("R10 offset 0x18", 5'h18, 32'h0);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule